// File: doc/BRIEF.md
# Block Read Engine with Local Staging FIFO

This engine moves a contiguous region of memory into a local FIFO so that a streaming consumer, such as a pixel pipeline, can pop words at its own pace. Software or a sequencer hands it a fill command made of a byte start address and a byte length. The engine cuts the region into read requests of bounded size and presents them in address order on a request channel. It caps how many reads may be in flight, and it issues a read only when the FIFO is sure to have room for every word that read will return.

As soon as the final request of a region has been handed off, the engine raises a one-cycle end-of-block pulse and will accept the next fill command, possibly for a different region, while earlier data is still returning. A drain input holds off new requests without disturbing responses already on their way. The consumer pops words through a valid/ready pair, and a sticky flag records any attempt to pop from an empty FIFO.

Lengths are counted in whole data words: the low address-offset bits of the length are dropped, and start addresses are expected to be word aligned. Each response beat carries one word, beats arrive in request order, and the final beat of each request is marked.

Top module: `dma_fill_engine`

## Requirements
- R1: `fillReady` is high exactly when no words of the current region remain unrequested; a fill is taken when `fillValid` and `fillReady` are both high, and its length is used as `fillLen >> log2(DATA_W/8)` words (the low offset bits are ignored).
- R2: The number of requests handed off (`reqValid` and `reqReady` high) minus the number of beats with `rspLast` high never exceeds `MAX_OUT`.
- R3: Each request length `reqLen`, in bytes, is nonzero and at most `MAX_REQ_BYTES`; the first request of a region uses the fill address, each later one starts at the previous address plus the previous `reqLen`, every request but the last has the full size, and the last carries the remainder.
- R4: `reqValid` is high only when words remain, fewer than `MAX_OUT` reads are open, and FIFO free entries minus words reserved for open reads is at least the request's word count; the FIFO never overflows.
- R5: `endOfBlock` is high for exactly one cycle, the cycle after the handshake of a region's last request, and `fillReady` is high in that cycle.
- R6: While `drain` is high, `reqValid` is low; response beats keep being written into the FIFO.
- R7: Every response beat writes `rspData` into the FIFO; `popValid` is high whenever the FIFO holds a word and `popData` presents words in arrival order.
- R8: `idle` is high exactly when no words remain unrequested and no read is open.
- R9: `underflow` rises the cycle after `popReady` is high while `popValid` is low and then stays high until reset.
- R10: After reset `reqValid`, `popValid`, `endOfBlock` and `underflow` are low and `fillReady` and `idle` are high.
- R11: A fill whose length is under one word is accepted, issues no request and raises no `endOfBlock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fillValid | input | 1 | Fill command present |
| fillReady | output | 1 | Engine can take a fill command |
| fillAddr | input | ADDR_W | Region start byte address |
| fillLen | input | LEN_W | Region length in bytes |
| drain | input | 1 | Hold off new read requests |
| reqValid | output | 1 | Read request present |
| reqReady | input | 1 | Memory side takes the request |
| reqAddr | output | ADDR_W | Request start byte address |
| reqLen | output | $clog2(MAX_REQ_BYTES+1) | Request length in bytes |
| rspValid | input | 1 | Response beat present |
| rspData | input | DATA_W | Response word |
| rspLast | input | 1 | Final beat of a request |
| popValid | output | 1 | FIFO holds a word |
| popReady | input | 1 | Consumer takes the word |
| popData | output | DATA_W | Oldest FIFO word |
| endOfBlock | output | 1 | Last request of a region was issued |
| idle | output | 1 | Nothing pending or open |
| underflow | output | 1 | Sticky empty-pop flag |

## Verification
The hardest state to reach from the ports is the one where the FIFO space check, not the in-flight cap, blocks the next request: open reservations plus stored words must fill the FIFO while words of the region still remain. The bench reaches it by starting a region twice the FIFO depth with the consumer stalled, so two full requests reserve every entry and the engine must sit with `reqValid` low until popping resumes. Drain is raised in the middle of a region while responses are still being returned, and a random phase varies request acceptance, response timing and popping so that reservations, returns and pops coincide in many orders.

// File: rtl/dma_fill_pkg.sv
package dma_fill_pkg;

  // Strobes from the control unit to the address datapath.
  typedef struct packed {
    logic load;     // capture a new region
    logic advance;  // current chunk was handed off
  } dpStrobe_t;

endpackage

// File: rtl/dma_fill_fifo.sv
module dma_fill_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReady,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  count,
  output logic              underflow
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;
  logic              doPop;

  assign popValid = (count != '0);
  assign doPop    = popValid && popReady;
  assign popData  = store[rdPtr];

  // Pointer wrap: free for power-of-two depths, compare otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : gPow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : gOdd
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      underflow <= 1'b0;
    end else begin
      if (push)  wrPtr <= wrNext;
      if (doPop) rdPtr <= rdNext;
      case ({push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (popReady && !popValid) underflow <= 1'b1;
    end
  end

  // R4: reservation upstream must keep the FIFO from overflowing
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CNT_W'(DEPTH)));

  // R7: a stalled head word stays available
  a_r7_head_held: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReady) |=> popValid);

  // R9: empty-pop flag is sticky
  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

endmodule

// File: rtl/dma_fill_addr.sv
module dma_fill_addr
  import dma_fill_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 16,
  parameter int DATA_W        = 32,
  parameter int MAX_REQ_BYTES = 16,
  localparam int BPW          = DATA_W / 8,
  localparam int OFS_W        = (BPW > 1) ? $clog2(BPW) : 0,
  localparam int MAX_WORDS    = MAX_REQ_BYTES / BPW,
  localparam int WLEN_W       = LEN_W - OFS_W,
  localparam int CHUNK_W      = $clog2(MAX_WORDS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [LEN_W-1:0]   fillLen,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [CHUNK_W-1:0] chunkWords,
  output logic               remZero,
  output logic               lastChunk
);

  logic [WLEN_W-1:0] remWords;
  logic              bigRem;

  assign bigRem     = (remWords > WLEN_W'(MAX_WORDS));
  assign chunkWords = bigRem ? CHUNK_W'(MAX_WORDS) : CHUNK_W'(remWords);
  assign remZero    = (remWords == '0);
  assign lastChunk  = !remZero && !bigRem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remWords <= '0;
    end else if (strobe.load) begin
      curAddr  <= fillAddr;
      remWords <= fillLen[LEN_W-1:OFS_W];
    end else if (strobe.advance) begin
      curAddr  <= curAddr + (ADDR_W'(chunkWords) << OFS_W);
      remWords <= remWords - WLEN_W'(chunkWords);
    end
  end

  // R3: a handed-off chunk is never empty and never exceeds the cap
  a_r3_chunk_bounds: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (chunkWords != '0 && chunkWords <= CHUNK_W'(MAX_WORDS)));

  // R1: a new region is only captured once the old one is fully requested
  a_r1_load_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> remZero);

endmodule

// File: rtl/dma_fill_ctrl.sv
module dma_fill_ctrl
  import dma_fill_pkg::*;
#(
  parameter int MAX_OUT    = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int CHUNK_W    = 3,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  output logic               fillReady,
  input  logic               drain,
  output logic               reqValid,
  input  logic               reqReady,
  input  logic               rspValid,
  input  logic               rspLast,
  input  logic               remZero,
  input  logic               lastChunk,
  input  logic [CHUNK_W-1:0] chunkWords,
  input  logic [CNT_W-1:0]   fifoCount,
  output dpStrobe_t          strobe,
  output logic               endOfBlock,
  output logic               idle
);

  logic [OUT_W-1:0] openReads;
  logic [CNT_W-1:0] reserved;
  logic [CNT_W:0]   room;
  logic             capOk, roomOk, issue;

  assign room   = (CNT_W + 1)'(FIFO_DEPTH) - {1'b0, fifoCount} - {1'b0, reserved};
  assign roomOk = (room >= (CNT_W + 1)'(chunkWords));
  assign capOk  = (openReads < OUT_W'(MAX_OUT));

  assign reqValid  = !remZero && !drain && capOk && roomOk;
  assign issue     = reqValid && reqReady;
  assign fillReady = remZero;
  assign idle      = remZero && (openReads == '0);

  always_comb begin
    strobe         = '0;
    strobe.load    = fillValid && fillReady;
    strobe.advance = issue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openReads  <= '0;
      reserved   <= '0;
      endOfBlock <= 1'b0;
    end else begin
      openReads <= openReads + OUT_W'(issue) - OUT_W'(rspValid && rspLast);
      reserved  <= reserved + (issue ? CNT_W'(chunkWords) : '0) - CNT_W'(rspValid);
      endOfBlock <= issue && lastChunk;
    end
  end

  // R2: open reads stay within the cap
  a_r2_open_cap: assert property (@(posedge clk) disable iff (!rstN)
    openReads <= OUT_W'(MAX_OUT));

  // R4: stored words plus reserved words fit in the FIFO
  a_r4_reserve_fits: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, fifoCount} + {1'b0, reserved}) <= (CNT_W + 1)'(FIFO_DEPTH));

  // R5: the pulse coincides with readiness for the next region
  a_r5_eob_ready: assert property (@(posedge clk) disable iff (!rstN)
    endOfBlock |-> fillReady);

endmodule

// File: rtl/dma_fill_engine.sv
module dma_fill_engine
  import dma_fill_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 16,
  parameter int DATA_W        = 32,
  parameter int MAX_REQ_BYTES = 16,
  parameter int MAX_OUT       = 2,
  parameter int FIFO_DEPTH    = 8,
  localparam int BPW          = DATA_W / 8,
  localparam int OFS_W        = (BPW > 1) ? $clog2(BPW) : 0,
  localparam int MAX_WORDS    = MAX_REQ_BYTES / BPW,
  localparam int CHUNK_W      = $clog2(MAX_WORDS + 1),
  localparam int RLEN_W       = $clog2(MAX_REQ_BYTES + 1),
  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillValid,
  output logic              fillReady,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LEN_W-1:0]  fillLen,
  input  logic              drain,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [RLEN_W-1:0] reqLen,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspLast,
  output logic              popValid,
  input  logic              popReady,
  output logic [DATA_W-1:0] popData,
  output logic              endOfBlock,
  output logic              idle,
  output logic              underflow
);

  dpStrobe_t          strobe;
  logic [CHUNK_W-1:0] chunkWords;
  logic               remZero, lastChunk;
  logic [CNT_W-1:0]   fifoCount;

  assign reqLen = RLEN_W'(chunkWords) << OFS_W;

  dma_fill_addr #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_REQ_BYTES(MAX_REQ_BYTES)
  ) u_addr (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillAddr(fillAddr), .fillLen(fillLen),
    .curAddr(reqAddr), .chunkWords(chunkWords),
    .remZero(remZero), .lastChunk(lastChunk)
  );

  dma_fill_ctrl #(
    .MAX_OUT(MAX_OUT), .FIFO_DEPTH(FIFO_DEPTH), .CHUNK_W(CHUNK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillReady(fillReady),
    .drain(drain), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspLast(rspLast),
    .remZero(remZero), .lastChunk(lastChunk), .chunkWords(chunkWords),
    .fifoCount(fifoCount), .strobe(strobe),
    .endOfBlock(endOfBlock), .idle(idle)
  );

  dma_fill_fifo #(
    .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk(clk), .rstN(rstN),
    .push(rspValid), .pushData(rspData),
    .popReady(popReady), .popValid(popValid), .popData(popData),
    .count(fifoCount), .underflow(underflow)
  );

  // R3: request size at the port is bounded and nonzero
  a_r3_len_cap: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != '0 && reqLen <= RLEN_W'(MAX_REQ_BYTES)));

  // R6: drain holds off the request channel
  a_r6_drain_blocks: assert property (@(posedge clk) disable iff (!rstN)
    drain |-> !reqValid);

  // R5: end-of-block is a single-cycle pulse
  a_r5_eob_pulse: assert property (@(posedge clk) disable iff (!rstN)
    endOfBlock |=> !endOfBlock);

endmodule

// File: tb/dma_fill_engine_bench.sv
module dma_fill_engine_bench;

  localparam int MAXW   = 4;
  localparam int MAXOUT = 2;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fillValid = 1'b0, fillReady;
  logic [31:0] fillAddr = '0;
  logic [15:0] fillLen = '0;
  logic        drain = 1'b0;
  logic        reqValid, reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic [4:0]  reqLen;
  logic        rspValid = 1'b0, rspLast = 1'b0;
  logic [31:0] rspData = '0;
  logic        popValid, popReady = 1'b0;
  logic [31:0] popData;
  logic        endOfBlock, idle, underflow;

  dma_fill_engine u_dma_fill_engine (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillReady(fillReady),
    .fillAddr(fillAddr), .fillLen(fillLen), .drain(drain),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .popValid(popValid), .popReady(popReady), .popData(popData),
    .endOfBlock(endOfBlock), .idle(idle), .underflow(underflow)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // knobs for the random drivers (percent)
  int reqPct = 100, rspPct = 100, popPct = 100;
  bit popEn = 1'b1, forcePop = 1'b0;

  // reference model state
  int          mRem = 0, mOut = 0, mRes = 0;
  logic [31:0] mAddr = '0;
  bit          mEob = 1'b0, mUnder = 1'b0;
  logic [31:0] fq[$];
  logic [31:0] rqAddr[$];
  int          rqWords[$];
  int          eobSeen = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison and model step, mid-cycle
  always @(negedge clk) begin
    if (!rstN) begin
      mRem = 0; mOut = 0; mRes = 0; mAddr = '0; mEob = 0; mUnder = 0;
      fq.delete(); rqAddr.delete(); rqWords.delete();
    end else begin
      int  chunk, room;
      bit  eReq, iss, fil, pop, und;
      logic [31:0] oldAddr;
      chunk = (mRem > MAXW) ? MAXW : mRem;
      room  = DEPTH - fq.size() - mRes;
      eReq  = (mRem != 0) && !drain && (mOut < MAXOUT) && (room >= chunk);
      check(reqValid == eReq, "R4 reqValid", reqValid, eReq);
      if (eReq && reqValid) begin
        check(reqAddr == mAddr, "R3 reqAddr", reqAddr, mAddr);
        check(int'(reqLen) == chunk * 4, "R3 reqLen", reqLen, chunk * 4);
      end
      if (drain) check(!reqValid, "R6 drain", reqValid, 0);
      check(fillReady == (mRem == 0), "R1 fillReady", fillReady, mRem == 0);
      check(idle == (mRem == 0 && mOut == 0), "R8 idle", idle, mRem == 0 && mOut == 0);
      check(popValid == (fq.size() != 0), "R7 popValid", popValid, fq.size() != 0);
      if (fq.size() != 0 && popValid) check(popData == fq[0], "R7 popData", popData, fq[0]);
      check(endOfBlock == mEob, "R5 endOfBlock", endOfBlock, mEob);
      check(underflow == mUnder, "R9 underflow", underflow, mUnder);
      check(mOut <= MAXOUT, "R2 open reads", mOut, MAXOUT);
      if (endOfBlock) eobSeen++;

      iss = eReq && reqReady;
      fil = fillValid && (mRem == 0);
      pop = popReady && (fq.size() != 0);
      und = popReady && (fq.size() == 0);
      mEob = iss && (chunk == mRem);
      if (iss) begin
        oldAddr = mAddr;
        mAddr = mAddr + 32'(chunk * 4);
        mRem  = mRem - chunk;
        mOut++;
        mRes += chunk;
        rqAddr.push_back(oldAddr);
        rqWords.push_back(chunk);
      end else if (fil) begin
        mAddr = fillAddr;
        mRem  = int'(fillLen >> 2);
      end
      if (pop) void'(fq.pop_front());
      if (rspValid) begin
        fq.push_back(rspData);
        mRes--;
        if (rspLast) mOut--;
        rqAddr[0] = rqAddr[0] + 32'd4;
        rqWords[0] = rqWords[0] - 1;
        if (rqWords[0] == 0) begin
          void'(rqAddr.pop_front());
          void'(rqWords.pop_front());
        end
      end
      if (und) mUnder = 1'b1;
    end
  end

  // memory responder and consumer, driven just after each edge
  always @(posedge clk) begin
    #1;
    reqReady = ($urandom_range(99) < reqPct);
    if (rstN && rqAddr.size() != 0 && $urandom_range(99) < rspPct) begin
      rspValid = 1'b1;
      rspData  = rqAddr[0] ^ 32'h5A5A0000;
      rspLast  = (rqWords[0] == 1);
    end else begin
      rspValid = 1'b0;
      rspLast  = 1'b0;
    end
    popReady = forcePop || (popEn && popValid && ($urandom_range(99) < popPct));
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic doFill(input logic [31:0] a, input logic [15:0] len);
    @(posedge clk); #2;
    fillAddr = a; fillLen = len; fillValid = 1'b1;
    do @(negedge clk); while (!fillReady);
    @(posedge clk); #2;
    fillValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!(idle && !popValid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n < 5000, req, n, 5000);
  endtask

  initial begin
    int eb;
    int sawReq;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check(!reqValid && !popValid && !endOfBlock && !underflow, "R10 outputs low",
          {reqValid, popValid, endOfBlock, underflow}, 0);
    check(fillReady && idle, "R10 ready and idle", {fillReady, idle}, 2'b11);

    // R3/R5: 40 bytes split 4+4+2 words, free flowing
    eb = eobSeen;
    doFill(32'h0000_1000, 16'd40);
    waitDone("R3 region drains");
    check(eobSeen == eb + 1, "R5 one pulse per region", eobSeen - eb, 1);

    // R4: consumer stalled, region larger than FIFO
    popEn = 1'b0;
    doFill(32'h0000_2000, 16'd64);
    repeat (40) @(negedge clk);
    check(!reqValid, "R4 blocked by reservation", reqValid, 0);
    check(popValid, "R7 FIFO holds data", popValid, 1);
    popEn = 1'b1;
    waitDone("R4 region completes after resume");

    // R6: drain in the middle of a region with responses in flight
    rspPct = 30;
    doFill(32'h0000_4000, 16'd96);
    repeat (3) @(negedge clk);
    @(posedge clk); #2 drain = 1'b1;
    sawReq = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (reqValid) sawReq++;
    end
    check(sawReq == 0, "R6 no requests while draining", sawReq, 0);
    @(posedge clk); #2 drain = 1'b0;
    rspPct = 100;
    waitDone("R6 region completes after drain");

    // R1/R3: random handshakes, length with ignored low bits (30 -> 7 words)
    reqPct = 50; rspPct = 60; popPct = 40;
    doFill(32'h0000_5000, 16'd30);
    doFill(32'h0000_7000, 16'd52);
    doFill(32'h0000_9000, 16'd20);
    for (int k = 0; k < 6; k++)
      doFill(32'h0001_0000 + 32'(k * 256), 16'(4 + k * 12));
    waitDone("R1 back-to-back regions drain");
    reqPct = 100; rspPct = 100; popPct = 100;

    // R11: sub-word fill issues nothing
    eb = eobSeen;
    doFill(32'h0000_A000, 16'd3);
    sawReq = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (reqValid) sawReq++;
    end
    check(sawReq == 0, "R11 no request", sawReq, 0);
    check(eobSeen == eb, "R11 no end-of-block", eobSeen - eb, 0);
    check(fillReady && idle, "R11 still ready", {fillReady, idle}, 2'b11);

    // R9: pop attempt on empty FIFO sets the sticky flag
    check(!underflow, "R9 clear before", underflow, 0);
    @(posedge clk); #2 forcePop = 1'b1;
    @(posedge clk); #2 forcePop = 1'b0;
    repeat (4) @(negedge clk);
    check(underflow, "R9 set and held", underflow, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule